// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block sits at the front of a serial-flash controller. It takes a bus address in the controller's memory range and decides which attached flash device, if any, owns it. Each chip-select has its own run-time programmable window. The window is described by an 8-bit start field and an 8-bit end field, and each field is counted in 8 MiB units. An address that falls inside a window selects that device. The block reports the position of the address relative to the start of that window. An address that falls in no window is reported as a decode error.

The segment registers are written and read through a small register port. A window whose start field is not below its end field is treated as closed and never matches. When the block is built for a single chip-select there are no segment registers, and the whole memory range maps to select 0, starting at offset 0. The lookup result is registered and appears one cycle after the address is presented.

Top module: `seg_window_decoder`

## Requirements
- R1: During and after reset, `dec_valid`, `cs_hit` and `decode_err` are 0 and `win_offset` is 0. Segment register n resets to a 32 MiB window: start field = (RANGE_BASE >> 23) + 4n and end field = start field + 4. With the defaults this reads back 0x4440_0000, 0x4844_0000 and 0x4C48_0000.
- R2: Segment register n sits at byte offset 0x30 + 4n on `reg_addr`. It is written when `reg_wr_en` is high at a clock edge. `reg_rdata` shows the addressed register combinationally. Bits 15:0 always read 0 and are not stored. Writes to any other offset have no effect, and reads of any other offset return 0.
- R3: Register bits 23:16 are the start field and bits 31:24 are the end field. Window n covers start<<23 up to but not including end<<23, and an address hits only inside that span.
- R4: A window whose start field is greater than or equal to its end field is closed. Its bit in `win_closed` is 1 and it never produces a hit.
- R5: When several open windows contain the address, only the lowest chip-select index is asserted. `cs_hit` never has more than one bit set.
- R6: On a hit, `win_offset` equals the bus address minus the start address of the selected window.
- R7: On a miss, `decode_err` is 1, `cs_hit` is 0 and `win_offset` is 0.
- R8: A lookup presented with `addr_valid` high is reported one cycle later, with `dec_valid` high for that single cycle. In cycles without `addr_valid`, `dec_valid` is 0 and `cs_hit`, `decode_err` and `win_offset` keep their values.
- R9: A lookup in the same cycle as a register write uses the register contents from before that write.
- R10: With NUM_CS = 1 there are no segment registers: reads return 0 and writes change nothing. An address in [RANGE_BASE, RANGE_BASE + RANGE_SIZE) hits select 0 with offset address − RANGE_BASE. Any other address is a miss, and `win_closed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Segment register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| addr_valid | input | 1 | Bus address present this cycle |
| bus_addr | input | ADDR_W | Bus address to decode |
| dec_valid | output | 1 | Lookup result valid |
| cs_hit | output | NUM_CS | One-hot selected chip-select |
| decode_err | output | 1 | Address matched no open window |
| win_offset | output | ADDR_W | Address relative to the selected window start |
| win_closed | output | NUM_CS | Per-select window closed flag |

## Verification
The hardest case to reach is priority between overlapping windows. The reset windows are disjoint, so two hits never compete unless the stimulus first widens one window over another. The bench therefore stretches select 2 over select 0's span and looks up an address both windows contain. It then closes select 0 by setting its start above its end and repeats the same lookup, so the winner has to move to the higher index. A random phase keeps every field inside a narrow band of granules around the range base, which makes overlaps, empty windows and the exact end boundaries occur often. A behavioural model checks all outputs every cycle, and a second instance built for a single chip-select runs alongside on the same stimulus.

// File: rtl/seg_window_pkg.sv
package seg_window_pkg;

   localparam int FIELD_W    = 8;
   localparam int GRAN_SHIFT = 23;
   localparam int REG_W      = 32;
   localparam int START_LSB  = 16;
   localparam int END_LSB    = 24;

   typedef struct packed {
      logic [FIELD_W-1:0] end_f;
      logic [FIELD_W-1:0] start_f;
   } seg_t;

   function automatic logic [REG_W-1:0] seg_pack(input seg_t s);
      logic [REG_W-1:0] w;
      w = '0;
      w[END_LSB +: FIELD_W]   = s.end_f;
      w[START_LSB +: FIELD_W] = s.start_f;
      return w;
   endfunction

   function automatic seg_t seg_unpack(input logic [REG_W-1:0] w);
      seg_t s;
      s.end_f   = w[END_LSB +: FIELD_W];
      s.start_f = w[START_LSB +: FIELD_W];
      return s;
   endfunction

endpackage

// File: rtl/seg_window_regs.sv
module seg_window_regs
   import seg_window_pkg::*;
#(
   parameter int NUM_CS     = 3,
   parameter int REG_AW     = 8,
   parameter int SEG_OFFSET = 'h30,
   parameter int RST_FIELD0 = 'h40,
   parameter int RST_STEP   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [REG_AW-1:0]      addr,
   input  logic [REG_W-1:0]       wdata,
   output logic [REG_W-1:0]       rdata,
   output seg_t [NUM_CS-1:0]      seg_o
);

   logic [NUM_CS-1:0] sel;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_seg
      localparam logic [REG_AW-1:0]  MY_OFF = REG_AW'(SEG_OFFSET + 4 * i);
      localparam logic [FIELD_W-1:0] RST_S  = FIELD_W'(RST_FIELD0 + RST_STEP * i);
      localparam logic [FIELD_W-1:0] RST_E  = FIELD_W'(RST_FIELD0 + RST_STEP * (i + 1));

      seg_t seg_q;

      assign sel[i] = (addr == MY_OFF);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seg_q.start_f <= RST_S;
            seg_q.end_f   <= RST_E;
         end else if (wr_en && sel[i]) begin
            seg_q <= seg_unpack(wdata);
         end
      end

      assign seg_o[i] = seg_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (sel[i]) rdata = rdata | seg_pack(seg_o[i]);
      end
   end

endmodule

// File: rtl/seg_window_match.sv
module seg_window_match
   import seg_window_pkg::*;
#(
   parameter int NUM_CS = 3,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]              addr,
   input  seg_t [NUM_CS-1:0]              seg_i,
   output logic [NUM_CS-1:0]              hit_raw,
   output logic [NUM_CS-1:0]              closed,
   output logic [NUM_CS-1:0][ADDR_W-1:0]  base_o
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_win
      logic [ADDR_W-1:0] lo;
      logic [ADDR_W-1:0] hi;

      assign lo         = ADDR_W'(seg_i[i].start_f) << GRAN_SHIFT;
      assign hi         = ADDR_W'(seg_i[i].end_f) << GRAN_SHIFT;
      assign closed[i]  = (seg_i[i].start_f >= seg_i[i].end_f);
      assign hit_raw[i] = !closed[i] && (addr >= lo) && (addr < hi);
      assign base_o[i]  = lo;
   end

endmodule

// File: rtl/seg_window_prio.sv
module seg_window_prio #(
   parameter int NUM_CS = 3,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [NUM_CS-1:0]              hit_raw,
   input  logic [NUM_CS-1:0][ADDR_W-1:0]  base_i,
   output logic [NUM_CS-1:0]              onehot,
   output logic                           any,
   output logic [ADDR_W-1:0]              offset
);

   logic [ADDR_W-1:0] sel_base;

   always_comb begin
      onehot   = '0;
      sel_base = '0;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (hit_raw[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            sel_base  = base_i[i];
         end
      end
   end

   assign any    = |hit_raw;
   assign offset = any ? (addr - sel_base) : '0;

endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder
   import seg_window_pkg::*;
#(
   parameter int              NUM_CS        = 3,
   parameter int              ADDR_W        = 32,
   parameter int              REG_AW        = 8,
   parameter int              SEG_OFFSET    = 'h30,
   parameter longint unsigned RANGE_BASE    = 64'h2000_0000,
   parameter longint unsigned RANGE_SIZE    = 64'h0400_0000,
   parameter int              RST_GRANULES  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic                addr_valid,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic                dec_valid,
   output logic [NUM_CS-1:0]   cs_hit,
   output logic                decode_err,
   output logic [ADDR_W-1:0]   win_offset,
   output logic [NUM_CS-1:0]   win_closed
);

   localparam int BASE_FIELD = int'(RANGE_BASE >> GRAN_SHIFT);
   localparam int LAST_FIELD = BASE_FIELD + RST_GRANULES * NUM_CS;

   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
      $error("NUM_CS must lie in 1..8");
   end
   if (ADDR_W < 31 || ADDR_W > 64) begin : g_bad_aw
      $error("ADDR_W must cover the 8-bit granule fields");
   end
   if ((RANGE_BASE & ((64'd1 << GRAN_SHIFT) - 1)) != 0) begin : g_bad_base
      $error("RANGE_BASE must be granule aligned");
   end
   if (NUM_CS > 1 && LAST_FIELD > 255) begin : g_bad_rst
      $error("reset windows exceed the field range");
   end
   if (REG_AW < 8) begin : g_bad_raw
      $error("REG_AW too narrow for segment offsets");
   end

   logic [NUM_CS-1:0] onehot_c;
   logic              any_c;
   logic [ADDR_W-1:0] off_c;

   if (NUM_CS == 1) begin : g_single
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(RANGE_BASE);
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(RANGE_BASE + RANGE_SIZE);
      logic in_rng;

      assign in_rng     = (bus_addr >= LO) && (bus_addr < HI);
      assign onehot_c   = NUM_CS'(in_rng);
      assign any_c      = in_rng;
      assign off_c      = in_rng ? (bus_addr - LO) : '0;
      assign reg_rdata  = '0;
      assign win_closed = '0;
   end else begin : g_multi
      seg_t [NUM_CS-1:0]             seg;
      logic [NUM_CS-1:0]             hit_raw;
      logic [NUM_CS-1:0][ADDR_W-1:0] base;

      seg_window_regs #(
         .NUM_CS     (NUM_CS),
         .REG_AW     (REG_AW),
         .SEG_OFFSET (SEG_OFFSET),
         .RST_FIELD0 (BASE_FIELD),
         .RST_STEP   (RST_GRANULES)
      ) regs_i (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (reg_wr_en),
         .addr  (reg_addr),
         .wdata (reg_wdata),
         .rdata (reg_rdata),
         .seg_o (seg)
      );

      seg_window_match #(
         .NUM_CS (NUM_CS),
         .ADDR_W (ADDR_W)
      ) match_i (
         .addr    (bus_addr),
         .seg_i   (seg),
         .hit_raw (hit_raw),
         .closed  (win_closed),
         .base_o  (base)
      );

      seg_window_prio #(
         .NUM_CS (NUM_CS),
         .ADDR_W (ADDR_W)
      ) prio_i (
         .addr    (bus_addr),
         .hit_raw (hit_raw),
         .base_i  (base),
         .onehot  (onehot_c),
         .any     (any_c),
         .offset  (off_c)
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         cs_hit     <= '0;
         decode_err <= 1'b0;
         win_offset <= '0;
      end else begin
         dec_valid <= addr_valid;
         if (addr_valid) begin
            cs_hit     <= onehot_c;
            decode_err <= !any_c;
            win_offset <= off_c;
         end
      end
   end

endmodule

// File: rtl/seg_window_decoder_chk.sv
module seg_window_decoder_chk #(
   parameter int NUM_CS = 3,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_valid,
   input logic              dec_valid,
   input logic [NUM_CS-1:0] cs_hit,
   input logic              decode_err,
   input logic [ADDR_W-1:0] win_offset,
   input logic [NUM_CS-1:0] win_closed
);

   // R8
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> dec_valid);

   // R8
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> !dec_valid);

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> ($stable(cs_hit) && $stable(win_offset) && $stable(decode_err)));

   // R5
   single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_hit));

   // R7
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && decode_err) |-> (cs_hit == '0 && win_offset == '0));

   // R7
   hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (decode_err != (cs_hit != '0)));

   for (genvar i = 0; i < NUM_CS; i++) begin : g_closed
      // R4
      closed_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && $past(addr_valid) && $past(win_closed[i])) |-> !cs_hit[i]);
   end

endmodule

bind seg_window_decoder seg_window_decoder_chk #(
   .NUM_CS (NUM_CS),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_valid (addr_valid),
   .dec_valid  (dec_valid),
   .cs_hit     (cs_hit),
   .decode_err (decode_err),
   .win_offset (win_offset),
   .win_closed (win_closed)
);

// File: tb/seg_window_decoder_tb_top.sv
module seg_window_decoder_tb_top;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        reg_wr_en;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic        addr_valid;
   logic [31:0] bus_addr;

   logic [31:0] reg_rdata, win_offset;
   logic [2:0]  cs_hit, win_closed;
   logic        decode_err, dec_valid;

   logic [31:0] r1_rdata, off1;
   logic [0:0]  hit1, closed1;
   logic        err1, val1;

   seg_window_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_valid(addr_valid),
      .bus_addr(bus_addr), .dec_valid(dec_valid), .cs_hit(cs_hit),
      .decode_err(decode_err), .win_offset(win_offset), .win_closed(win_closed)
   );

   seg_window_decoder #(.NUM_CS(1)) dut1_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(r1_rdata), .addr_valid(addr_valid),
      .bus_addr(bus_addr), .dec_valid(val1), .cs_hit(hit1),
      .decode_err(err1), .win_offset(off1), .win_closed(closed1)
   );

   int n_checks = 0;
   int n_fail   = 0;

   logic [31:0] m_seg [3];
   logic        e_valid, e_err, e1_valid, e1_err;
   logic [2:0]  e_hit;
   logic [0:0]  e1_hit;
   logic [31:0] e_off, e1_off;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void mdec(input logic [31:0] a, output logic [2:0] h,
                                output logic [31:0] o, output logic err);
      h = '0; o = '0; err = 1'b1;
      for (int i = 0; i < 3; i++) begin
         longint unsigned s = longint'(m_seg[i][23:16]) << 23;
         longint unsigned e = longint'(m_seg[i][31:24]) << 23;
         if (err && m_seg[i][23:16] < m_seg[i][31:24] && a >= s && a < e) begin
            h   = 3'(1 << i);
            o   = a - 32'(s);
            err = 1'b0;
         end
      end
   endfunction

   function automatic logic [31:0] mread(input logic [7:0] ad);
      for (int i = 0; i < 3; i++)
         if (ad == 8'(8'h30 + 4 * i)) return m_seg[i];
      return 32'h0;
   endfunction

   function automatic logic [2:0] mclosed();
      logic [2:0] c;
      for (int i = 0; i < 3; i++) c[i] = (m_seg[i][23:16] >= m_seg[i][31:24]);
      return c;
   endfunction

   // one clock: drive at negedge, compare full state at the next negedge
   task automatic step(input logic we, input logic [7:0] ra, input logic [31:0] wd,
                       input logic av, input logic [31:0] ba);
      reg_wr_en  = we;
      reg_addr   = ra;
      reg_wdata  = wd;
      addr_valid = av;
      bus_addr   = ba;
      e_valid    = av;
      e1_valid   = av;
      if (av) begin
         mdec(ba, e_hit, e_off, e_err);
         if (ba >= 32'h2000_0000 && ba < 32'h2400_0000) begin
            e1_hit = 1'b1; e1_off = ba - 32'h2000_0000; e1_err = 1'b0;
         end else begin
            e1_hit = 1'b0; e1_off = 32'h0; e1_err = 1'b1;
         end
      end
      if (we)
         for (int i = 0; i < 3; i++)
            if (ra == 8'(8'h30 + 4 * i)) m_seg[i] = wd & 32'hFFFF_0000;
      @(posedge clk);
      @(negedge clk);
      chk("R8", "dec_valid", 32'(dec_valid), 32'(e_valid));
      chk("R3", "cs_hit", 32'(cs_hit), 32'(e_hit));
      chk("R7", "decode_err", 32'(decode_err), 32'(e_err));
      chk("R6", "win_offset", win_offset, e_off);
      chk("R4", "win_closed", 32'(win_closed), 32'(mclosed()));
      chk("R2", "reg_rdata", reg_rdata, mread(ra));
      chk("R10", "single dec_valid", 32'(val1), 32'(e1_valid));
      chk("R10", "single cs_hit", 32'(hit1), 32'(e1_hit));
      chk("R10", "single decode_err", 32'(err1), 32'(e1_err));
      chk("R10", "single offset", off1, e1_off);
      chk("R10", "single rdata", r1_rdata, 32'h0);
      chk("R10", "single closed", 32'(closed1), 32'h0);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      m_seg[0] = 32'h4440_0000;
      m_seg[1] = 32'h4844_0000;
      m_seg[2] = 32'h4C48_0000;
      e_valid = 0; e_err = 0; e_hit = '0; e_off = '0;
      e1_valid = 0; e1_err = 0; e1_hit = '0; e1_off = '0;
      rst_n = 1'b0; reg_wr_en = 0; reg_addr = 8'h30; reg_wdata = 0;
      addr_valid = 0; bus_addr = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "dec_valid in reset", 32'(dec_valid), 32'h0);
      chk("R1", "cs_hit in reset", 32'(cs_hit), 32'h0);
      chk("R1", "decode_err in reset", 32'(decode_err), 32'h0);
      chk("R1", "win_offset in reset", win_offset, 32'h0);
      rst_n = 1'b1;
      step(0, 8'h30, 0, 0, 0);
      chk("R1", "seg0 reset", reg_rdata, 32'h4440_0000);
      step(0, 8'h34, 0, 0, 0);
      chk("R1", "seg1 reset", reg_rdata, 32'h4844_0000);
      step(0, 8'h38, 0, 0, 0);
      chk("R1", "seg2 reset", reg_rdata, 32'h4C48_0000);

      // R3 boundaries with exclusive end
      step(0, 8'h30, 0, 1, 32'h2200_0000);
      chk("R3", "end excl -> cs1", 32'(cs_hit), 32'h2);
      chk("R6", "cs1 offset 0", win_offset, 32'h0);
      step(0, 8'h30, 0, 1, 32'h21FF_FFFF);
      chk("R3", "last byte cs0", 32'(cs_hit), 32'h1);
      chk("R6", "cs0 last offset", win_offset, 32'h01FF_FFFF);
      step(0, 8'h30, 0, 1, 32'h2600_0000);
      chk("R7", "above windows miss", 32'(decode_err), 32'h1);
      step(0, 8'h30, 0, 1, 32'h1FFF_FFFF);
      chk("R7", "below windows miss", 32'(cs_hit), 32'h0);
      step(0, 8'h30, 0, 0, 32'h2000_0000);
      chk("R8", "no lookup no valid", 32'(dec_valid), 32'h0);
      chk("R8", "hold after idle", 32'(decode_err), 32'h1);

      // R9 same-cycle write uses old registers
      step(1, 8'h30, 32'h4040_0000, 1, 32'h2000_0000);
      chk("R9", "old window used", 32'(cs_hit), 32'h1);
      step(0, 8'h30, 0, 1, 32'h2000_0000);
      chk("R9", "new closed window", 32'(decode_err), 32'h1);
      chk("R4", "start==end closed", 32'(win_closed), 32'h1);

      // R2 stray offsets and low bits
      step(1, 8'h3C, 32'h5040_0000, 0, 0);
      chk("R2", "offset 0x3C reads 0", reg_rdata, 32'h0);
      step(1, 8'h00, 32'h5040_0000, 0, 0);
      chk("R2", "offset 0x00 reads 0", reg_rdata, 32'h0);
      step(1, 8'h30, 32'h4440_ABCD, 0, 0);
      chk("R2", "low bits dropped", reg_rdata, 32'h4440_0000);

      // R5 overlap priority
      step(1, 8'h38, 32'h4C40_0000, 0, 0);
      step(0, 8'h30, 0, 1, 32'h2100_0000);
      chk("R5", "lowest index wins", 32'(cs_hit), 32'h1);
      chk("R6", "cs0 overlap offset", win_offset, 32'h0100_0000);
      step(1, 8'h30, 32'h0040_0000, 0, 0);
      step(0, 8'h30, 0, 1, 32'h2100_0000);
      chk("R5", "falls to cs2", 32'(cs_hit), 32'h4);
      chk("R6", "cs2 offset", win_offset, 32'h0100_0000);
      chk("R4", "start>end closed", 32'(win_closed), 32'h1);

      // R10 single-select variant
      step(0, 8'h30, 0, 1, 32'h23FF_FFFF);
      chk("R10", "single last hit", off1, 32'h03FF_FFFF);
      step(0, 8'h30, 0, 1, 32'h2400_0000);
      chk("R10", "single beyond range", 32'(err1), 32'h1);

      // mixed traffic in a narrow field band
      for (int k = 0; k < 600; k++) begin
         logic        we, av;
         logic [7:0]  ra, sf, ef;
         logic [31:0] wd, ba;
         we = ($urandom % 4) == 0;
         av = ($urandom % 4) != 0;
         case ($urandom % 5)
            0: ra = 8'h30;
            1: ra = 8'h34;
            2: ra = 8'h38;
            3: ra = 8'h3C;
            default: ra = 8'h00;
         endcase
         sf = 8'(8'h3E + $urandom % 16);
         ef = 8'(8'h3E + $urandom % 16);
         wd = {ef, sf, 16'($urandom)};
         ba = 32'h1F00_0000 + ($urandom % 32'h0900_0000);
         if (($urandom % 3) == 0) ba = {ba[31:23], 23'h0};
         step(we, ra, wd, av, ba);
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule